// File: doc/BRIEF.md
# Quadrature Direct Digital Frequency Synthesizer

This core produces a sine sample and a cosine sample of the same phase on each enabled clock. A wide phase register adds a frequency word on every enabled edge, so the tone frequency is the word times the clock rate divided by 2^24. The top bits of the phase select one of eight octants. The remaining bits are mirrored into the first octant and split into a coarse index and a fine remainder.

The coarse index reads a small table that holds the sine and cosine of angles in [0, π/4) only. Each table point sits at the centre of its coarse interval. A first-order correction, value ± (other value × fine angle), rebuilds the full-resolution pair. The fine angle in radians comes from the fine remainder through a constant multiply, so the fine part needs no table. The corrected magnitudes are clamped to the signed 16-bit range. Final logic then swaps and negates them to suit the true octant.

The datapath has four register stages. Each stage loads only when a valid sample is moving through it, and the output holds its last sample when no new one arrives.

Top module: `quad_ddfs`

## Requirements
- R1: While reset is high, sinOut and cosOut are 0 and sampleValid is 0. The phase register returns to 0.
- R2: Every rising edge with enable high emits one sample and then adds freqWord to the 24-bit phase, modulo 2^24. The first sample after reset has phase 0. A later sample has the sum of all earlier words taken while enable was high, and this holds for words of 2^23 and above (negative frequencies).
- R3: While enable is low, the phase register does not advance. On cycles where sampleValid is low, sinOut and cosOut hold the last valid sample.
- R4: When enable is high at rising edge k, sampleValid is high, and the sample is on the outputs, in the cycle after edge k+3. sampleValid is high only in such cycles.
- R5: sinOut is within 4 LSB of min(32767, round(32768·sin(2π·q/2^18))), where q is the phase shifted right by 6 bits.
- R6: cosOut is within 4 LSB of min(32767, round(32768·cos(2π·q/2^18))), with q defined as in R5.
- R7: The octant is q[17:15]. sinOut is ≥ 0 in octants 0–3 and ≤ 0 in octants 4–7. cosOut is ≥ 0 in octants 0, 1, 6 and 7, and ≤ 0 in the other four. Accuracy holds over all octants.
- R8: Outputs never take the value −32768. Full-scale points land within 1 LSB of ±32767: cosine at phase 0, sine at phase 0x400000, cosine at 0x800000 and sine at 0xC00000.
- R9: A change of freqWord keeps the phase continuous. The first sample under the new word continues from the accumulated phase, and the phase register is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Emit a sample and advance the phase on this edge |
| freqWord | input | 24 | Phase increment per enabled edge |
| sinOut | output | 16 | Signed sine sample, full scale 32767 |
| cosOut | output | 16 | Signed cosine sample, full scale 32767 |
| sampleValid | output | 1 | The outputs hold a new sample this cycle |

## Verification
A sample asked for at rising edge k is due in the cycle after edge k+3, three edges after the sampling edge. The driver tags each expected item with the index of the edge that samples it. The monitor looks at the outputs on the falling edge and requires that the oldest item's edge index plus three equals the current edge count. In cycles where sampleValid is low, the monitor checks that no item is due and that both outputs still hold the previous sample. Expected sine and cosine values come from real-valued functions of a phase that the bench accumulates on its own.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;

  // Octant selection is fixed by the eight-fold symmetry of sine and cosine
  localparam int OCT_W = 3;

  // pi/4 scaled by 2^16, used to turn a fine phase remainder into radians
  localparam int PI4_Q16 = 51472;

  // Per-stage load strobes handed from control to datapath
  typedef struct packed {
    logic step;   // capture phase and advance the accumulator
    logic load2;  // coarse table read and fine-angle stage
    logic load3;  // correction products stage
    logic load4;  // sum, clamp and octant unfold stage
  } ddfsStrobe_t;

endpackage

// File: rtl/ddfs_ctrl.sv
module ddfs_ctrl
  import ddfs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  output ddfsStrobe_t strobe,
  output logic        sampleValid
);

  localparam int STAGES = 4;

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[STAGES-2:0], enable};
  end

  always_comb begin
    strobe.step  = enable;
    strobe.load2 = validPipe[0];
    strobe.load3 = validPipe[1];
    strobe.load4 = validPipe[2];
  end

  assign sampleValid = validPipe[STAGES-1];

  // Edges seen since reset, saturating, so the delay check never reaches before reset
  logic [2:0] resetAge;
  always_ff @(posedge clk) begin
    if (rst) resetAge <= '0;
    else if (resetAge != 3'd4) resetAge <= resetAge + 3'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (resetAge == 3'd4) |-> (sampleValid == $past(enable, 4))); // R4

endmodule

// File: rtl/ddfs_coarse_rom.sv
module ddfs_coarse_rom #(
  parameter int CA_W  = 6,
  parameter int ROM_W = 16
) (
  input  logic              clk,
  input  logic              load,
  input  logic [CA_W-1:0]   addr,
  output logic [ROM_W-1:0]  sinCoarse,
  output logic [ROM_W-1:0]  cosCoarse
);

  localparam int     TAB_N    = 2 ** CA_W;
  localparam longint ONE_Q30  = 64'sd1 << 30;
  localparam longint PI4_Q30  = 64'sd843314857;
  localparam int     SHIFT    = 30 - (ROM_W - 1);
  localparam longint HALF_LSB = 64'sd1 << (SHIFT - 1);

  function automatic longint q30Mul(input longint a, input longint b);
    return (a * b) >>> 30;
  endfunction

  // Table points sit at the centre of each coarse interval of [0, pi/4)
  function automatic logic [TAB_N*ROM_W-1:0] buildImage(input bit wantSin);
    logic [TAB_N*ROM_W-1:0] img;
    longint x, x2, t, v;
    img = '0;
    for (int a = 0; a < TAB_N; a++) begin
      x  = ((2 * longint'(a) + 1) * PI4_Q30) / (2 * TAB_N);
      x2 = q30Mul(x, x);
      if (wantSin) begin
        t = ONE_Q30 - x2 / 72;
        t = ONE_Q30 - q30Mul(x2, t) / 42;
        t = ONE_Q30 - q30Mul(x2, t) / 20;
        t = ONE_Q30 - q30Mul(x2, t) / 6;
        v = q30Mul(x, t);
      end else begin
        t = ONE_Q30 - x2 / 90;
        t = ONE_Q30 - q30Mul(x2, t) / 56;
        t = ONE_Q30 - q30Mul(x2, t) / 30;
        t = ONE_Q30 - q30Mul(x2, t) / 12;
        t = ONE_Q30 - q30Mul(x2, t) / 2;
        v = t;
      end
      img[a*ROM_W +: ROM_W] = ROM_W'((v + HALF_LSB) >>> SHIFT);
    end
    return img;
  endfunction

  localparam logic [TAB_N*ROM_W-1:0] SIN_IMG = buildImage(1'b1);
  localparam logic [TAB_N*ROM_W-1:0] COS_IMG = buildImage(1'b0);

  always_ff @(posedge clk) begin
    if (load) begin
      sinCoarse <= SIN_IMG[addr*ROM_W +: ROM_W];
      cosCoarse <= COS_IMG[addr*ROM_W +: ROM_W];
    end
  end

endmodule

// File: rtl/ddfs_datapath.sv
module ddfs_datapath
  import ddfs_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int PH_W       = 18,
  parameter int CA_W       = 6,
  parameter int OUT_W      = 16,
  parameter int DELTA_FRAC = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ddfsStrobe_t             strobe,
  input  logic [ACC_W-1:0]        freqWord,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut
);

  localparam int FOLD_W  = PH_W - OCT_W;
  localparam int FINE_W  = FOLD_W - CA_W;
  localparam int RD_W    = FINE_W + 1 + 17;
  localparam int DSH     = 16 + FOLD_W - DELTA_FRAC;
  localparam int DELTA_W = FINE_W + 1 + DELTA_FRAC - FOLD_W;
  localparam int PROD_W  = OUT_W + 1 + DELTA_W;
  localparam int SUM_W   = OUT_W + 3;

  localparam logic signed [FINE_W:0]     HALF_FINE = (FINE_W+1)'(2 ** (FINE_W - 1));
  localparam logic signed [RD_W-1:0]     PI4_K     = RD_W'(PI4_Q16);
  localparam logic signed [PROD_W-1:0]   ROUND_K   = PROD_W'(2 ** (DELTA_FRAC - 1));
  localparam logic signed [SUM_W-1:0]    MAX_MAG   = SUM_W'(2 ** (OUT_W - 1) - 1);

  // Stage 1: phase accumulator
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  ph1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ph1 <= '0;
    end else if (strobe.step) begin
      ph1 <= acc[ACC_W-1 -: PH_W];
      acc <= acc + freqWord;
    end
  end

  // Fold into the first octant, split coarse index and fine remainder
  logic [OCT_W-1:0]        oct1;
  logic [FOLD_W-1:0]       rest1, fold1;
  logic [CA_W-1:0]         addr1;
  logic [FINE_W-1:0]       fine1;
  logic signed [FINE_W:0]  resid1;
  logic signed [RD_W-1:0]  rad1;

  always_comb begin
    oct1   = ph1[PH_W-1 -: OCT_W];
    rest1  = ph1[FOLD_W-1:0];
    fold1  = oct1[0] ? ~rest1 : rest1;
    addr1  = fold1[FOLD_W-1 -: CA_W];
    fine1  = fold1[FINE_W-1:0];
    resid1 = $signed({1'b0, fine1}) - HALF_FINE;
    rad1   = RD_W'(resid1) * PI4_K;
  end

  // Stage 2: coarse values and fine angle in radians
  logic [OUT_W-1:0]           sinC2, cosC2;
  logic signed [DELTA_W-1:0]  delta2;
  logic [OCT_W-1:0]           oct2;

  ddfs_coarse_rom #(.CA_W(CA_W), .ROM_W(OUT_W)) u_rom (
    .clk       (clk),
    .load      (strobe.load2),
    .addr      (addr1),
    .sinCoarse (sinC2),
    .cosCoarse (cosC2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      delta2 <= '0;
      oct2   <= '0;
    end else if (strobe.load2) begin
      delta2 <= DELTA_W'(rad1 >>> DSH);
      oct2   <= oct1;
    end
  end

  // Stage 3: correction products
  logic signed [PROD_W-1:0] prodS3, prodC3;
  logic [OUT_W-1:0]         sinC3, cosC3;
  logic [OCT_W-1:0]         oct3;

  always_ff @(posedge clk) begin
    if (rst) begin
      prodS3 <= '0;
      prodC3 <= '0;
      sinC3  <= '0;
      cosC3  <= '0;
      oct3   <= '0;
    end else if (strobe.load3) begin
      prodS3 <= PROD_W'($signed({1'b0, cosC2})) * PROD_W'(delta2);
      prodC3 <= PROD_W'($signed({1'b0, sinC2})) * PROD_W'(delta2);
      sinC3  <= sinC2;
      cosC3  <= cosC2;
      oct3   <= oct2;
    end
  end

  // Stage 4: add, clamp, unfold
  function automatic logic [OUT_W-1:0] clampMag(input logic signed [SUM_W-1:0] v);
    if (v < 0)            return '0;
    else if (v > MAX_MAG) return MAX_MAG[OUT_W-1:0];
    else                  return v[OUT_W-1:0];
  endfunction

  logic signed [PROD_W-1:0] rndS, rndC;
  logic signed [SUM_W-1:0]  corrS, corrC, sumS, sumC;
  logic [OUT_W-1:0]         magS, magC, firstV, secondV;
  logic                     swapSel, negSin, negCos;

  always_comb begin
    rndS    = prodS3 + ROUND_K;
    rndC    = prodC3 + ROUND_K;
    corrS   = SUM_W'(rndS >>> DELTA_FRAC);
    corrC   = SUM_W'(rndC >>> DELTA_FRAC);
    sumS    = $signed({3'b000, sinC3}) + corrS;
    sumC    = $signed({3'b000, cosC3}) - corrC;
    magS    = clampMag(sumS);
    magC    = clampMag(sumC);
    swapSel = oct3[0] ^ oct3[1];
    negSin  = oct3[2];
    negCos  = oct3[1] ^ oct3[2];
    firstV  = swapSel ? magC : magS;
    secondV = swapSel ? magS : magC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sinOut <= '0;
      cosOut <= '0;
    end else if (strobe.load4) begin
      sinOut <= negSin ? -$signed(firstV)  : $signed(firstV);
      cosOut <= negCos ? -$signed(secondV) : $signed(secondV);
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.step |=> $stable(acc)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.load4 |=> ($stable(sinOut) && $stable(cosOut))); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sinOut != {1'b1, {(OUT_W-1){1'b0}}}) && (cosOut != {1'b1, {(OUT_W-1){1'b0}}})); // R8

  AST_SIN_SIGN: assert property (@(posedge clk) disable iff (rst)
    strobe.load4 |=> ($past(oct3[2]) ? (sinOut <= 0) : (sinOut >= 0))); // R7

  AST_COS_SIGN: assert property (@(posedge clk) disable iff (rst)
    strobe.load4 |=> (($past(oct3[1]) ^ $past(oct3[2])) ? (cosOut <= 0) : (cosOut >= 0))); // R7

endmodule

// File: rtl/quad_ddfs.sv
module quad_ddfs
  import ddfs_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int PH_W       = 18,
  parameter int CA_W       = 6,
  parameter int OUT_W      = 16,
  parameter int DELTA_FRAC = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic [ACC_W-1:0]        freqWord,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut,
  output logic                    sampleValid
);

  ddfsStrobe_t strobe;

  ddfs_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .strobe      (strobe),
    .sampleValid (sampleValid)
  );

  ddfs_datapath #(
    .ACC_W      (ACC_W),
    .PH_W       (PH_W),
    .CA_W       (CA_W),
    .OUT_W      (OUT_W),
    .DELTA_FRAC (DELTA_FRAC)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .freqWord (freqWord),
    .sinOut   (sinOut),
    .cosOut   (cosOut)
  );

endmodule

// File: tb/sim_quad_ddfs.sv
module sim_quad_ddfs;

  localparam int CLK_PERIOD = 10;
  localparam real TWO_PI = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               enable = 1'b0;
  logic [23:0]        freqWord = '0;
  logic signed [15:0] sinOut, cosOut;
  logic               sampleValid;

  quad_ddfs u0 (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .freqWord    (freqWord),
    .sinOut      (sinOut),
    .cosOut      (cosOut),
    .sampleValid (sampleValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    issue;
    int    sinRef;
    int    cosRef;
    int    tol;
    string reqS;
    string reqC;
  } expItem_t;

  expItem_t expQ[$];
  int  cycleCnt = 0;
  int  nChecks  = 0;
  int  nFails   = 0;
  bit  done     = 0;
  bit  haveLast = 0;
  int  lastS, lastC;
  longint accRef = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input string req, input string what, input int act, input int expv, input int tol);
    int diff;
    diff = act - expv;
    if (diff < 0) diff = -diff;
    nChecks++;
    if (diff > tol) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int refVal(input longint ph, input bit wantSin);
    real ang, v;
    int r;
    ang = TWO_PI * real'(ph >> 6) / 262144.0;
    v = wantSin ? 32768.0 * $sin(ang) : 32768.0 * $cos(ang);
    r = int'(v);
    if (r > 32767) r = 32767;
    return r;
  endfunction

  // Driver: one call per cycle
  task automatic drive(input bit e, input logic [23:0] w, input int tol, input string rs, input string rc);
    expItem_t it;
    @(negedge clk);
    enable   = e;
    freqWord = w;
    if (e) begin
      it.issue  = cycleCnt + 1;
      it.sinRef = refVal(accRef, 1'b1);
      it.cosRef = refVal(accRef, 1'b0);
      it.tol    = tol;
      it.reqS   = rs;
      it.reqC   = rc;
      expQ.push_back(it);
      accRef = (accRef + longint'(w)) & 64'hFF_FFFF;
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sampleValid) begin
        if (expQ.size() == 0) begin
          check("R4", "valid with nothing pending", 1, 0, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check("R4", "sample edge", cycleCnt, it.issue + 3, 0);
          check(it.reqS, "sinOut", sinOut, it.sinRef, it.tol);
          check(it.reqC, "cosOut", cosOut, it.cosRef, it.tol);
          if (sinOut == -32768 || cosOut == -32768)
            check("R8", "most negative code", -32768, -32767, 0);
          lastS = sinOut;
          lastC = cosOut;
          haveLast = 1;
        end
      end else begin
        if (expQ.size() > 0 && expQ[0].issue + 3 == cycleCnt)
          check("R4", "missing valid", 0, 1, 0);
        if (haveLast) begin
          check("R3", "sinOut hold", sinOut, lastS, 0);
          check("R3", "cosOut hold", cosOut, lastC, 0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycleCnt, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b1;  // ignored under reset
    freqWord = 24'h123456;
    repeat (2) @(negedge clk);
    check("R1", "sinOut in reset", sinOut, 0, 0);
    check("R1", "cosOut in reset", cosOut, 0, 0);
    check("R1", "valid in reset", sampleValid, 0, 0);
    enable = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) drive(1'b0, 24'h0, 0, "R1", "R1");

    // Quarter steps from phase 0: first sample at phase 0, full-scale corners
    drive(1'b1, 24'h400000, 1, "R2", "R8");
    drive(1'b1, 24'h400000, 1, "R8", "R8");
    drive(1'b1, 24'h400000, 1, "R8", "R8");
    drive(1'b1, 24'h400000, 1, "R8", "R8");

    for (int i = 0; i < 30; i++) drive(1'b1, 24'h001234, 4, "R5", "R6");
    for (int i = 0; i < 200; i++) drive(1'b1, 24'h123457, 4, "R5", "R6");

    // Gap with enable low: phase must hold
    for (int i = 0; i < 6; i++) drive(1'b0, 24'h7FFFFF, 4, "R3", "R3");
    drive(1'b1, 24'h0F0F0F, 4, "R3", "R3");

    // Word change with no break
    for (int i = 0; i < 100; i++) drive(1'b1, 24'h0F0F0F, 4, "R9", "R9");
    for (int i = 0; i < 40; i++) drive(1'b1, 24'h00A5A5, 4, "R9", "R9");

    // Full-circle sweep across every octant
    for (int i = 0; i < 1100; i++) drive(1'b1, 24'h004001, 4, "R7", "R7");

    // Alternating enable
    for (int i = 0; i < 40; i++) drive(i[0], 24'h031415, 4, "R4", "R4");

    // Negative frequency
    for (int i = 0; i < 100; i++) drive(1'b1, 24'hFF8765, 4, "R2", "R2");

    for (int i = 0; i < 8; i++) drive(1'b0, 24'h0, 0, "R3", "R3");
    check("R4", "items left undelivered", expQ.size(), 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule